// File: doc/BRIEF.md
# Eviction-History Reuse Predictor

This block sits beside a cache controller and predicts whether a block that just missed is likely to be reused soon. It keeps a compact, lossy record of the addresses the cache has recently evicted. The record is a flop-based bit vector addressed by two fixed hash functions. When the cache evicts a block, the controller presents the victim address on the eviction port, and the block sets the two bits that address hashes to. When the cache misses, the controller presents the missed address on the lookup port. One cycle later the block returns a verdict. The verdict is high reuse when both hashed bits are already set, meaning the address was evicted recently. Otherwise it is low reuse.

The block never removes a single address. An address that tests positive stays recorded. To stop the record from filling up and to bound how many blocks can be judged high-reuse, a fill counter counts insertions since the last wipe. When the counter reaches its configured limit, the whole vector and the counter are wiped in one cycle. This periodic wipe is what keeps a working set that is too large for the cache from thrashing. False positives from hash aliasing are accepted, because the output is only a hint.

Cache hits never reach this block. Where the missed block is placed in the cache is left to the controller.

Top module: `reuse_filter`

## Requirements
- R1: A synchronous active-low reset clears every vector bit, the fill counter and both verdict outputs. Any lookup made after reset and before the next eviction returns low reuse.
- R2: On an eviction that does not trigger a wipe, the block computes two indices, h0 and h1, and sets both bits. h0 is the XOR of the consecutive IDX_W-bit chunks of the address, counted from bit 0 and zero-padded at the top. h1 is the same fold applied to the address shifted right by IDX_W/2 bits. A later lookup of that address returns high reuse.
- R3: A lookup returns high reuse only when the bits at both of its indices are set. If either bit is clear, it returns low reuse.
- R4: The verdict_valid output is high exactly in the cycle after a cycle in which lookup_valid was sampled high, and low otherwise.
- R5: When an eviction and a lookup arrive in the same cycle, the lookup sees the vector as it was before that eviction.
- R6: A lookup never changes the vector or the counter. An address that tests high reuse keeps testing high reuse until a wipe or reset occurs.
- R7: The fill counter counts evictions since the last wipe, from 0 up to CLEAR_LIMIT-1. The CLEAR_LIMIT-th eviction after a wipe or reset clears every vector bit and the counter together, so every earlier address then tests low reuse.
- R8: The eviction that triggers a wipe is not recorded. The wipe takes priority, so that eviction's own address also tests low reuse afterwards.
- R9: verdict_reuse is never high while verdict_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| evict_valid | input | 1 | The cache evicted a block this cycle |
| evict_addr | input | ADDR_W | Block address of the victim |
| lookup_valid | input | 1 | The cache missed this cycle and asks for a verdict |
| lookup_addr | input | ADDR_W | Block address of the miss |
| verdict_valid | output | 1 | A verdict for the previous cycle's lookup is present |
| verdict_reuse | output | 1 | 1 = high reuse (recently evicted), 0 = low reuse |

## Verification
The bound checker watches the following on every cycle:
- the one-cycle verdict timing and the quiet verdict when no lookup was made;
- the fill counter's range and its step on each eviction;
- the vector staying unchanged when no eviction occurs;
- both hashed bits being set after a recording eviction;
- the one-cycle wipe of vector and counter.

Other behaviours depend on address history and can only be shown by the bench's scenarios:
- the hash definition itself;
- a lookup seeing the vector from before a same-cycle eviction;
- a one-bit alias testing low;
- a positive lookup leaving its address in place;
- every address, including the triggering one, going absent after a wipe.

// File: rtl/reuse_filter_pkg.sv
package reuse_filter_pkg;
   // Number of hash functions applied to every address.
   localparam int unsigned NUM_HASH = 2;

   // Right shift applied to the address before folding, for hash k.
   function automatic int unsigned hash_shift(input int unsigned k, input int unsigned idx_w);
      return k * (idx_w / 2);
   endfunction
endpackage

// File: rtl/rf_hash.sv
module rf_hash #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned IDX_W  = 10,
   parameter int unsigned SHIFT  = 0
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [IDX_W-1:0]  idx
);
   localparam int unsigned SRC_W  = ADDR_W - SHIFT;
   localparam int unsigned CHUNKS = (SRC_W + IDX_W - 1) / IDX_W;
   localparam int unsigned PAD_W  = CHUNKS * IDX_W;

   if (SHIFT >= ADDR_W) begin : g_bad_shift
      $error("rf_hash: SHIFT must be below ADDR_W");
   end

   logic [PAD_W-1:0] padded;

   always_comb begin
      padded = '0;
      padded[SRC_W-1:0] = addr[ADDR_W-1:SHIFT];
      idx = '0;
      for (int unsigned c = 0; c < CHUNKS; c++) begin
         idx = idx ^ padded[c*IDX_W +: IDX_W];
      end
   end
endmodule

// File: rtl/rf_fill_counter.sv
module rf_fill_counter #(
   parameter int unsigned CLEAR_LIMIT = 256,
   parameter int unsigned CNT_W       = $clog2(CLEAR_LIMIT + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   output logic [CNT_W-1:0] count,
   output logic             wipe
);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(CLEAR_LIMIT - 1);

   assign wipe = inc && (count == LAST);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count <= '0;
      end else if (wipe) begin
         count <= '0;
      end else if (inc) begin
         count <= count + CNT_W'(1);
      end
   end
endmodule

// File: rtl/rf_bitvec.sv
module rf_bitvec #(
   parameter int unsigned VEC_LEN = 1024,
   parameter int unsigned IDX_W   = $clog2(VEC_LEN)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               set_en,
   input  logic [IDX_W-1:0]   set_idx0,
   input  logic [IDX_W-1:0]   set_idx1,
   input  logic               wipe,
   input  logic [IDX_W-1:0]   probe_idx0,
   input  logic [IDX_W-1:0]   probe_idx1,
   output logic               both_set,
   output logic [VEC_LEN-1:0] bits
);
   for (genvar i = 0; i < VEC_LEN; i++) begin : g_bit
      logic hit_here;
      assign hit_here = set_en &&
                        ((set_idx0 == IDX_W'(i)) || (set_idx1 == IDX_W'(i)));
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            bits[i] <= 1'b0;
         end else if (wipe) begin
            bits[i] <= 1'b0;
         end else if (hit_here) begin
            bits[i] <= 1'b1;
         end
      end
   end

   assign both_set = bits[probe_idx0] & bits[probe_idx1];
endmodule

// File: rtl/reuse_filter.sv
module reuse_filter #(
   parameter int unsigned ADDR_W      = 32,
   parameter int unsigned VEC_LEN     = 1024,
   parameter int unsigned CLEAR_LIMIT = 256
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              evict_valid,
   input  logic [ADDR_W-1:0] evict_addr,
   input  logic              lookup_valid,
   input  logic [ADDR_W-1:0] lookup_addr,
   output logic              verdict_valid,
   output logic              verdict_reuse
);
   import reuse_filter_pkg::*;

   localparam int unsigned IDX_W = $clog2(VEC_LEN);
   localparam int unsigned CNT_W = $clog2(CLEAR_LIMIT + 1);

   if ((1 << IDX_W) != VEC_LEN) begin : g_bad_len
      $error("reuse_filter: VEC_LEN must be a power of two");
   end
   if (IDX_W < 2) begin : g_bad_small
      $error("reuse_filter: VEC_LEN must be at least 4");
   end
   if (CLEAR_LIMIT < 1) begin : g_bad_limit
      $error("reuse_filter: CLEAR_LIMIT must be at least 1");
   end
   if (ADDR_W <= IDX_W) begin : g_bad_addr
      $error("reuse_filter: ADDR_W must exceed the index width");
   end

   logic [NUM_HASH-1:0][IDX_W-1:0] ins_idx;
   logic [NUM_HASH-1:0][IDX_W-1:0] probe_idx;

   for (genvar k = 0; k < NUM_HASH; k++) begin : g_hash
      rf_hash #(
         .ADDR_W(ADDR_W),
         .IDX_W (IDX_W),
         .SHIFT (hash_shift(k, IDX_W))
      ) u_ins_hash (
         .addr(evict_addr),
         .idx (ins_idx[k])
      );
      rf_hash #(
         .ADDR_W(ADDR_W),
         .IDX_W (IDX_W),
         .SHIFT (hash_shift(k, IDX_W))
      ) u_probe_hash (
         .addr(lookup_addr),
         .idx (probe_idx[k])
      );
   end

   logic [CNT_W-1:0]   fill_count;
   logic               wipe;
   logic               both_set;
   logic [VEC_LEN-1:0] filter_bits;

   rf_fill_counter #(
      .CLEAR_LIMIT(CLEAR_LIMIT),
      .CNT_W      (CNT_W)
   ) u_counter (
      .clk  (clk),
      .rst_n(rst_n),
      .inc  (evict_valid),
      .count(fill_count),
      .wipe (wipe)
   );

   rf_bitvec #(
      .VEC_LEN(VEC_LEN),
      .IDX_W  (IDX_W)
   ) u_vec (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_en    (evict_valid),
      .set_idx0  (ins_idx[0]),
      .set_idx1  (ins_idx[1]),
      .wipe      (wipe),
      .probe_idx0(probe_idx[0]),
      .probe_idx1(probe_idx[1]),
      .both_set  (both_set),
      .bits      (filter_bits)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         verdict_valid <= 1'b0;
         verdict_reuse <= 1'b0;
      end else begin
         verdict_valid <= lookup_valid;
         verdict_reuse <= lookup_valid && both_set;
      end
   end
endmodule

// File: rtl/reuse_filter_checker.sv
module reuse_filter_checker #(
   parameter int unsigned VEC_LEN     = 1024,
   parameter int unsigned CLEAR_LIMIT = 256,
   parameter int unsigned IDX_W       = $clog2(VEC_LEN),
   parameter int unsigned CNT_W       = $clog2(CLEAR_LIMIT + 1)
) (
   input logic               clk,
   input logic               rst_n,
   input logic               evict_valid,
   input logic               lookup_valid,
   input logic               verdict_valid,
   input logic               verdict_reuse,
   input logic [CNT_W-1:0]   fill_count,
   input logic [VEC_LEN-1:0] bits,
   input logic [IDX_W-1:0]   ins_idx0,
   input logic [IDX_W-1:0]   ins_idx1
);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(CLEAR_LIMIT - 1);

   // R1: a sampled reset leaves everything cleared at the next edge
   assert_reset_clears_R1: assert property (@(posedge clk)
      !rst_n |=> (bits == '0) && (fill_count == '0) && !verdict_valid && !verdict_reuse);

   // R2: a recording eviction leaves both of its bits set
   assert_insert_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (evict_valid && fill_count != LAST) |=> bits[$past(ins_idx0)] && bits[$past(ins_idx1)]);

   // R4: verdict follows a lookup by exactly one cycle
   assert_verdict_after_lookup_R4: assert property (@(posedge clk) disable iff (!rst_n)
      lookup_valid |=> verdict_valid);
   assert_no_stray_verdict_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !lookup_valid |=> !verdict_valid);

   // R6: without an eviction the vector and counter hold
   assert_lookup_no_change_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !evict_valid |=> $stable(bits) && $stable(fill_count));

   // R7: counter range, step and wipe
   assert_count_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
      fill_count <= LAST);
   assert_count_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (evict_valid && fill_count != LAST) |=> fill_count == $past(fill_count) + CNT_W'(1));
   // R8: the wipe wins over the triggering insert
   assert_wipe_all_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (evict_valid && fill_count == LAST) |=> (bits == '0) && (fill_count == '0));

   // R9: no reuse flag without a verdict
   assert_quiet_verdict_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !verdict_valid |-> !verdict_reuse);
endmodule

bind reuse_filter reuse_filter_checker #(
   .VEC_LEN    (VEC_LEN),
   .CLEAR_LIMIT(CLEAR_LIMIT),
   .IDX_W      (IDX_W),
   .CNT_W      (CNT_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .evict_valid  (evict_valid),
   .lookup_valid (lookup_valid),
   .verdict_valid(verdict_valid),
   .verdict_reuse(verdict_reuse),
   .fill_count   (fill_count),
   .bits         (filter_bits),
   .ins_idx0     (ins_idx[0]),
   .ins_idx1     (ins_idx[1])
);

// File: tb/reuse_filter_bench.sv
`timescale 1ns/1ps
module reuse_filter_bench;
   localparam int unsigned AW    = 16;
   localparam int unsigned VL    = 64;
   localparam int unsigned IW    = 6;
   localparam int unsigned LIMIT = 12;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          evict_valid = 1'b0;
   logic [AW-1:0] evict_addr = '0;
   logic          lookup_valid = 1'b0;
   logic [AW-1:0] lookup_addr = '0;
   logic          verdict_valid;
   logic          verdict_reuse;

   int checks = 0;
   int failures = 0;
   bit mvec [VL];
   int mcnt = 0;

   always #4 clk = ~clk;

   reuse_filter #(
      .ADDR_W(AW), .VEC_LEN(VL), .CLEAR_LIMIT(LIMIT)
   ) u_reuse_filter (
      .clk(clk), .rst_n(rst_n),
      .evict_valid(evict_valid), .evict_addr(evict_addr),
      .lookup_valid(lookup_valid), .lookup_addr(lookup_addr),
      .verdict_valid(verdict_valid), .verdict_reuse(verdict_reuse)
   );

   // Hash from R2: XOR-fold of IW-bit chunks of (addr >> shift).
   function automatic int unsigned fold(input logic [AW-1:0] a, input int unsigned shift);
      logic [AW-1:0] s = a >> shift;
      int unsigned r = 0;
      for (int unsigned c = 0; c < (AW + IW - 1) / IW; c++) begin
         r = r ^ ((s >> (c * IW)) & ((1 << IW) - 1));
      end
      return r;
   endfunction

   function automatic bit model_has(input logic [AW-1:0] a);
      return mvec[fold(a, 0)] && mvec[fold(a, IW / 2)];
   endfunction

   task automatic model_clear();
      for (int i = 0; i < VL; i++) mvec[i] = 1'b0;
      mcnt = 0;
   endtask

   task automatic model_evict(input logic [AW-1:0] a);
      if (mcnt == LIMIT - 1) begin
         model_clear();
      end else begin
         mvec[fold(a, 0)] = 1'b1;
         mvec[fold(a, IW / 2)] = 1'b1;
         mcnt++;
      end
   endtask

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // One clock: drive, predict, step, then compare away from the edge.
   task automatic step(input bit ev, input logic [AW-1:0] ea,
                       input bit lv, input logic [AW-1:0] la,
                       input string req, output bit got);
      bit exp_reuse;
      evict_valid = ev; evict_addr = ea;
      lookup_valid = lv; lookup_addr = la;
      exp_reuse = lv && model_has(la);   // R5: pre-eviction view
      if (ev) model_evict(ea);
      @(posedge clk); #1;
      check(verdict_valid == lv, req, verdict_valid, lv);
      check(verdict_reuse == exp_reuse, req, verdict_reuse, exp_reuse);
      got = verdict_reuse;
      evict_valid = 1'b0; lookup_valid = 1'b0;
   endtask

   task automatic do_reset();
      rst_n = 1'b0; evict_valid = 1'b0; lookup_valid = 1'b0;
      @(posedge clk); #1;
      check(verdict_valid == 1'b0, "R1", verdict_valid, 0);
      check(verdict_reuse == 1'b0, "R1", verdict_reuse, 0);
      @(posedge clk); #1;
      rst_n = 1'b1;
      model_clear();
   endtask

   task automatic report();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   initial begin
      #(8 * 200000);
      failures++;
      $display("FAIL watchdog expired");
      report();
   end

   initial begin
      bit g;
      logic [AW-1:0] a_addr, b_addr, c_addr, d_addr;
      logic [AW-1:0] pool [16];
      void'($urandom(32'd20240917));
      a_addr = 16'h1234;
      b_addr = a_addr ^ 16'h0041;   // same h0, different h1
      c_addr = 16'hBEEF;
      d_addr = 16'h7A5C;

      do_reset();
      // R1: empty after reset
      step(0, '0, 1, a_addr, "R1", g);
      check(g == 1'b0, "R1", g, 0);

      // R2: record then find
      step(1, a_addr, 0, '0, "R2", g);
      step(0, '0, 1, a_addr, "R2", g);
      check(g == 1'b1, "R2", g, 1);

      // R3: one-bit alias reads low
      check(fold(b_addr, 0) == fold(a_addr, 0), "R3", fold(b_addr, 0), fold(a_addr, 0));
      step(0, '0, 1, b_addr, "R3", g);
      check(g == 1'b0, "R3", g, 0);

      // R5: same-cycle insert and lookup sees old contents
      step(1, c_addr, 1, c_addr, "R5", g);
      check(g == 1'b0, "R5", g, 0);
      step(0, '0, 1, c_addr, "R5", g);
      check(g == 1'b1, "R5", g, 1);

      // R6: repeated positive lookups keep the address
      for (int i = 0; i < 4; i++) step(0, '0, 1, a_addr, "R6", g);
      check(g == 1'b1, "R6", g, 1);

      // R4 and R9: idle cycles give no verdict
      step(0, '0, 0, '0, "R4", g);
      check(verdict_reuse == 1'b0, "R9", verdict_reuse, 0);

      // R7 and R8: fill up to the limit, last eviction wipes
      while (mcnt < LIMIT - 1) step(1, AW'($urandom), 0, '0, "R7", g);
      step(1, d_addr, 0, '0, "R8", g);
      check(mcnt == 0, "R7", mcnt, 0);
      step(0, '0, 1, a_addr, "R7", g);
      check(g == 1'b0, "R7", g, 0);
      step(0, '0, 1, d_addr, "R8", g);
      check(g == 1'b0, "R8", g, 0);

      // R1: reset in the middle wipes recorded addresses
      step(1, a_addr, 0, '0, "R2", g);
      do_reset();
      step(0, '0, 1, a_addr, "R1", g);
      check(g == 1'b0, "R1", g, 0);

      // Random traffic against the model (R2, R3, R5, R6, R7)
      for (int i = 0; i < 16; i++) pool[i] = AW'($urandom);
      for (int n = 0; n < 4000; n++) begin
         bit ev = ($urandom % 3) == 0;
         bit lv = ($urandom % 2) == 0;
         logic [AW-1:0] ea = (($urandom % 4) != 0) ? pool[$urandom % 16] : AW'($urandom);
         logic [AW-1:0] la = (($urandom % 4) != 0) ? pool[$urandom % 16] : AW'($urandom);
         step(ev, ea, lv, la, "R3", g);
      end

      report();
   end
endmodule